// File: doc/BRIEF.md
# Banked GPIO Controller with Guarded Claim Words

This block is a memory-mapped general-purpose I/O controller. Its pins are grouped into banks of 32, with one to eight banks chosen by a parameter. A pin's bank is its number shifted right by five, and its bit inside the bank is the low five bits of the number. Software reaches the block over a plain 32-bit bus: a write strobe, a byte address, write data, and read data that follows the address combinationally. The pads are three vectors: the sampled input level, the driven level, and a drive-enable.

Each bank has these registers: a driven-level register, a synchronised input view, write-one set and clear ports for the driven levels, interrupt status, interrupt mask set and interrupt mask clear. Each bank also has a claim word. Every pin has its own configuration word with three fields: a direction bit, a two-bit edge selector and a four-bit debounce field, which is stored and read back but drives nothing. A pin set as an input raises its interrupt status bit when its selected edge appears on the synchronised input. A small sequencer guards the claim words. It has two states, `UL_LOCKED` and `UL_ARMED`. A key write moves it from UL_LOCKED to UL_ARMED (transition *arm*). The first later claim-word write takes effect and moves it back to UL_LOCKED (transition *consume*). A key write with any other value also moves it back to UL_LOCKED (transition *cancel*). In UL_LOCKED, claim-word writes are dropped.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: After reset, every configuration word reads 0x1 (input, no edge, debounce 0), `pad_oe` and `pad_out` are all zero, every claim word reads 0xFFFFFFFF, every mask reads 0xFFFFFFFF and `irq` is low.
- R2: A write to the set port (0x040 + 4*bank) makes the driven bits high where the data has ones. A write to the clear port (0x060 + 4*bank) makes them low where the data has ones. Zero data bits leave the level unchanged. The level reads back at 0x000 + 4*bank and appears on `pad_out` after the write edge.
- R3: `pad_oe` for a pin is 1 exactly when bit 0 of its configuration word is 0 (output). A 1 in bit 0 means input.
- R4: A read at 0x020 + 4*bank returns the bank's pad inputs after a two-flop synchroniser. A pad change made before clock edge k reads back once edge k+1 has passed.
- R5: The edge selector is bits 4:3 of the configuration word: 0 means none, 1 rising, 2 falling, 3 both. A pin with bit 0 = 1 latches its status bit (0x080 + 4*bank) on its selected edge of the synchronised input. A pin with bit 0 = 0 never latches a status bit.
- R6: Writing ones to the status register clears those bits. Ones written at 0x0A0 + 4*bank set mask bits, and ones written at 0x0C0 + 4*bank clear them. The mask reads back at 0x0A0. `irq` is the OR of the status bits whose mask bit is 0.
- R7: A write of 0x00A5A501 to 0x520 arms the sequencer. The next write to any bank's claim word (0x500 + 4*bank) stores its data and disarms. A second claim write without a new key is dropped.
- R8: A claim-word write while unarmed is dropped. Writing any value other than the key to 0x520 while armed disarms.
- R9: A configuration word at 0x100 + 4*pin stores bit 0, bits 4:3 and bits 8:5. All other bits read as 0.
- R10: Bank-indexed registers select the bank with address bits 4:2. An index at or above the bank count reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NUM_BANKS*32 | Pad input levels, asynchronous |
| pad_out | output | NUM_BANKS*32 | Driven pad levels |
| pad_oe | output | NUM_BANKS*32 | Pad drive enables, 1 means output |
| irq | output | 1 | OR of unmasked interrupt status bits |

## Verification
If the sequencer holds the wrong state, the fault shows on the first claim-word read after a claim write. The word either changes when it should have stayed at its old value, or stays when it should have changed, so the bench reads every claim word back straight after each write. If the edge detector's previous-value register or a status bit is wrong, `irq` or the status read goes wrong within three cycles of the pad change. A wrong configuration bit shows on `pad_oe` in the cycle after the write.

// File: rtl/gpio_banked_pkg.sv
package gpio_banked_pkg;

    localparam int BANK_PINS = 32;

    // address bits 11:5 pick the register group
    localparam logic [6:0] GRP_OUT  = 7'h00;
    localparam logic [6:0] GRP_IN   = 7'h01;
    localparam logic [6:0] GRP_SET  = 7'h02;
    localparam logic [6:0] GRP_CLR  = 7'h03;
    localparam logic [6:0] GRP_IST  = 7'h04;
    localparam logic [6:0] GRP_IMSK = 7'h05;
    localparam logic [6:0] GRP_IMCL = 7'h06;
    localparam logic [6:0] GRP_LOCK = 7'h28;

    localparam logic [11:0] CFG_BASE   = 12'h100;
    localparam logic [11:0] KEY_ADDR   = 12'h520;
    localparam logic [31:0] UNLOCK_KEY = 32'h00A5A501;

    typedef enum logic {
        UL_LOCKED = 1'b0,
        UL_ARMED  = 1'b1
    } unlock_state_e;

    typedef struct packed {
        logic [3:0] deb;
        logic [1:0] edge_sel;   // bit0 rising, bit1 falling
        logic       dir_in;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{deb: 4'd0, edge_sel: 2'd0, dir_in: 1'b1};

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_in,
    input  logic [WIDTH-1:0] is_input,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    input  logic [WIDTH-1:0] w1c,
    input  logic [WIDTH-1:0] mask_set,
    input  logic [WIDTH-1:0] mask_clr,
    output logic [WIDTH-1:0] status,
    output logic [WIDTH-1:0] mask
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] hit;

    always_comb begin
        hit = is_input & ((sync_in & ~prev_q & rise_en) |
                          (~sync_in & prev_q & fall_en));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            status <= '0;
            mask   <= '1;
        end else begin
            prev_q <= sync_in;
            status <= (status & ~w1c) | hit;
            mask   <= (mask | mask_set) & ~mask_clr;
        end
    end
endmodule

// File: rtl/gpio_unlock_fsm.sv
module gpio_unlock_fsm
    import gpio_banked_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_wr,
    input  logic key_ok,
    input  logic lock_wr,
    output logic armed,
    output logic lock_we
);
    unlock_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UL_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UL_LOCKED: if (key_wr && key_ok) state_d = UL_ARMED;         // arm
            UL_ARMED: begin
                if (key_wr && !key_ok) state_d = UL_LOCKED;              // cancel
                else if (lock_wr)      state_d = UL_LOCKED;              // consume
            end
            default: state_d = UL_LOCKED;
        endcase
    end

    always_comb begin
        armed   = 1'b0;
        lock_we = 1'b0;
        unique case (state_q)
            UL_LOCKED: ;
            UL_ARMED: begin
                armed   = 1'b1;
                lock_we = lock_wr;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl #(
    parameter int NUM_BANKS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [11:0]             bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic [NUM_BANKS*32-1:0] pad_in,
    output logic [NUM_BANKS*32-1:0] pad_out,
    output logic [NUM_BANKS*32-1:0] pad_oe,
    output logic                    irq
);
    import gpio_banked_pkg::*;

    localparam int NPINS  = NUM_BANKS * BANK_PINS;
    localparam int PIN_W  = $clog2(NPINS);
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam logic [9:0] NPINS_L = 10'(NPINS);
    localparam logic [3:0] NBANK_L = 4'(NUM_BANKS);

    // decode
    logic [6:0]        grp;
    logic [BANK_W-1:0] bsel;
    logic [BANK_W+4:0] base;
    logic              bank_ok;
    logic [11:0]       cfg_off;
    logic              cfg_hit;
    logic [PIN_W-1:0]  pin_idx;
    logic              unused_bits;

    assign grp     = bus_addr[11:5];
    assign bsel    = bus_addr[2 +: BANK_W];
    assign base    = {bsel, 5'b00000};
    assign bank_ok = ({1'b0, bus_addr[4:2]} < NBANK_L);
    assign cfg_off = bus_addr - CFG_BASE;
    assign cfg_hit = (bus_addr >= CFG_BASE) && (cfg_off[11:2] < NPINS_L);
    assign pin_idx = cfg_off[PIN_W+1:2];
    assign unused_bits = ^{bus_addr[1:0], cfg_off[1:0]};

    // state
    logic [NPINS-1:0] out_q, lock_q, sync_in;
    logic [NPINS-1:0] dir_flat, rise_flat, fall_flat;
    logic [NPINS-1:0] stat_flat, mask_flat;
    pin_cfg_t         cfg_q [NPINS];
    logic             armed, lock_we;

    gpio_sync2 #(.WIDTH(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_in)
    );

    gpio_unlock_fsm u_unlock (
        .clk    (clk),
        .rst_n  (rst_n),
        .key_wr (bus_wr && (bus_addr == KEY_ADDR)),
        .key_ok (bus_wdata == UNLOCK_KEY),
        .lock_wr(bus_wr && bank_ok && (grp == GRP_LOCK)),
        .armed  (armed),
        .lock_we(lock_we)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            lock_q <= '1;
        end else if (bus_wr && bank_ok) begin
            if (grp == GRP_SET) out_q[base +: 32] <= out_q[base +: 32] | bus_wdata;
            if (grp == GRP_CLR) out_q[base +: 32] <= out_q[base +: 32] & ~bus_wdata;
            if (lock_we)        lock_q[base +: 32] <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPINS; i++) cfg_q[i] <= CFG_RESET;
        end else if (bus_wr && cfg_hit) begin
            cfg_q[pin_idx] <= '{deb: bus_wdata[8:5], edge_sel: bus_wdata[4:3],
                                dir_in: bus_wdata[0]};
        end
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign dir_flat[p]  = cfg_q[p].dir_in;
        assign rise_flat[p] = cfg_q[p].edge_sel[0];
        assign fall_flat[p] = cfg_q[p].edge_sel[1];
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = bus_wr && bank_ok && (bus_addr[4:2] == 3'(b));
        gpio_irq_bank #(.WIDTH(BANK_PINS)) u_irq (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_in (sync_in[b*32 +: 32]),
            .is_input(dir_flat[b*32 +: 32]),
            .rise_en (rise_flat[b*32 +: 32]),
            .fall_en (fall_flat[b*32 +: 32]),
            .w1c     ((sel && grp == GRP_IST)  ? bus_wdata : 32'd0),
            .mask_set((sel && grp == GRP_IMSK) ? bus_wdata : 32'd0),
            .mask_clr((sel && grp == GRP_IMCL) ? bus_wdata : 32'd0),
            .status  (stat_flat[b*32 +: 32]),
            .mask    (mask_flat[b*32 +: 32])
        );
    end

    assign pad_out = out_q;
    assign pad_oe  = ~dir_flat;
    assign irq     = |(stat_flat & ~mask_flat);

    always_comb begin
        bus_rdata = 32'd0;
        if (cfg_hit) begin
            bus_rdata = {23'd0, cfg_q[pin_idx].deb, cfg_q[pin_idx].edge_sel,
                         2'b00, cfg_q[pin_idx].dir_in};
        end else if (bank_ok) begin
            case (grp)
                GRP_OUT:  bus_rdata = out_q[base +: 32];
                GRP_IN:   bus_rdata = sync_in[base +: 32];
                GRP_IST:  bus_rdata = stat_flat[base +: 32];
                GRP_IMSK: bus_rdata = mask_flat[base +: 32];
                GRP_LOCK: bus_rdata = lock_q[base +: 32];
                default:  bus_rdata = 32'd0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_banked_chk.sv
module gpio_banked_chk
    import gpio_banked_pkg::*;
#(
    parameter int NPINS = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [11:0]      bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [NPINS-1:0] pad_out,
    input logic             irq,
    input logic             armed,
    input logic             lock_we,
    input logic [NPINS-1:0] lock_flat,
    input logic [NPINS-1:0] stat_flat,
    input logic [NPINS-1:0] mask_flat,
    input logic [NPINS-1:0] dir_flat
);
    // R1
    all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_flat) |-> !irq);

    // R2
    set_drives_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 12'h040) |=> ((pad_out[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

    // R2
    clear_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 12'h060) |=> ((pad_out[31:0] & $past(bus_wdata)) == 32'd0));

    // R5
    output_pin_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_flat & ~$past(stat_flat) & ~$past(dir_flat)) == '0));

    // R7
    claim_consumes_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_we |=> !armed);

    // R8
    claim_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_flat != $past(lock_flat)) |-> $past(armed));
endmodule

bind gpio_banked_ctrl gpio_banked_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .pad_out  (pad_out),
    .irq      (irq),
    .armed    (armed),
    .lock_we  (lock_we),
    .lock_flat(lock_q),
    .stat_flat(stat_flat),
    .mask_flat(mask_flat),
    .dir_flat (dir_flat)
);

// File: tb/tb_gpio_banked_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_banked_ctrl;
    localparam int NB = 2;
    localparam int NP = NB * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    gpio_banked_ctrl #(.NUM_BANKS(NB)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, {32'd0, bus_rdata}, {32'd0, exp});
    endtask

    task automatic t_reset;
        rd_chk("R1 cfg pin0", 12'h100, 32'h1);
        rd_chk("R1 cfg pin63", 12'h1FC, 32'h1);
        rd_chk("R1 claim bank1", 12'h504, 32'hFFFF_FFFF);
        rd_chk("R1 mask bank0", 12'h0A0, 32'hFFFF_FFFF);
        rd_chk("R1 out bank0", 12'h000, 32'h0);
        chk("R1 pad_oe", pad_oe, 64'd0);
        chk("R1 pad_out", pad_out, 64'd0);
        chk("R1 irq", {63'd0, irq}, 64'd0);
    endtask

    task automatic t_drive;
        wr(12'h10C, 32'h0);   // pin 3 output
        wr(12'h1A0, 32'h0);   // pin 40 output (bank1 bit8, R10)
        @(negedge clk);
        chk("R3 pad_oe", pad_oe, 64'h0000_0100_0000_0008);
        wr(12'h040, 32'h0000_00F0);
        rd_chk("R2 set", 12'h000, 32'h0000_00F0);
        wr(12'h060, 32'h0000_0030);
        rd_chk("R2 clear", 12'h000, 32'h0000_00C0);
        wr(12'h044, 32'h0000_0100);
        chk("R2 R10 bank1 pad_out", pad_out, 64'h0000_0100_0000_00C0);
    endtask

    task automatic t_cfg;
        wr(12'h114, 32'hFFFF_FFFF);
        rd_chk("R9 cfg fields", 12'h114, 32'h0000_01F9);
        wr(12'h114, 32'h0000_0006);
        rd_chk("R9 unused bits", 12'h114, 32'h0);
        @(negedge clk);
        chk("R3 pin5 output", {63'd0, pad_oe[5]}, 64'd1);
        wr(12'h114, 32'h1);
    endtask

    task automatic t_input;
        @(negedge clk);
        pad_in = {32'h0000_00A5, 32'h0000_1234};
        repeat (3) @(negedge clk);
        rd_chk("R4 in bank0", 12'h020, 32'h0000_1234);
        rd_chk("R4 in bank1", 12'h024, 32'h0000_00A5);
        @(negedge clk);
        pad_in = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_edge;
        wr(12'h128, 32'h09);   // pin10 rising
        wr(12'h12C, 32'h11);   // pin11 falling
        wr(12'h130, 32'h19);   // pin12 both
        wr(12'h134, 32'h01);   // pin13 none
        wr(12'h10C, 32'h18);   // pin3 output, both edges
        @(negedge clk);
        pad_in[13:10] = 4'hF;
        pad_in[3] = 1'b1;
        repeat (4) @(negedge clk);
        rd_chk("R5 rising/both", 12'h080, 32'h0000_1400);
        chk("R6 masked irq", {63'd0, irq}, 64'd0);
        wr(12'h0C0, 32'h0000_0400);
        rd_chk("R6 mask clear", 12'h0A0, 32'hFFFF_FBFF);
        chk("R6 irq unmasked", {63'd0, irq}, 64'd1);
        wr(12'h080, 32'h0000_0400);
        rd_chk("R6 w1c", 12'h080, 32'h0000_1000);
        chk("R6 irq after w1c", {63'd0, irq}, 64'd0);
        @(negedge clk);
        pad_in[13:10] = 4'h0;
        pad_in[3] = 1'b0;
        repeat (4) @(negedge clk);
        rd_chk("R5 falling/both, output pin", 12'h080, 32'h0000_1800);
        wr(12'h0C0, 32'h0000_0800);
        chk("R6 irq pin11", {63'd0, irq}, 64'd1);
        wr(12'h0A0, 32'h0000_0C00);
        chk("R6 mask set", {63'd0, irq}, 64'd0);
        wr(12'h080, 32'h0000_1800);
        rd_chk("R6 status cleared", 12'h080, 32'h0);
    endtask

    task automatic t_claim;
        wr(12'h500, 32'h0);
        rd_chk("R8 no key", 12'h500, 32'hFFFF_FFFF);
        wr(12'h520, 32'h00A5_A501);
        wr(12'h500, 32'hFFFF_0000);
        rd_chk("R7 keyed claim", 12'h500, 32'hFFFF_0000);
        wr(12'h500, 32'h0);
        rd_chk("R7 key used up", 12'h500, 32'hFFFF_0000);
        wr(12'h520, 32'h00A5_A501);
        wr(12'h520, 32'h0000_1234);
        wr(12'h504, 32'h0);
        rd_chk("R8 cancelled", 12'h504, 32'hFFFF_FFFF);
        wr(12'h520, 32'h00A5_A501);
        wr(12'h504, 32'h0000_000F);
        rd_chk("R7 other bank", 12'h504, 32'h0000_000F);
    endtask

    task automatic t_range;
        wr(12'h048, 32'hFFFF_FFFF);
        chk("R10 write ignored", pad_out, 64'h0000_0100_0000_00C0);
        rd_chk("R10 read zero", 12'h008, 32'h0);
        rd_chk("R10 claim zero", 12'h508, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_drive();
        t_cfg();
        t_input();
        t_edge();
        t_claim();
        t_range();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule